// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps instruction fetch ahead of execution. As long as it has room, it issues fetch requests to memory for fixed-size 32-bit instructions at consecutive byte addresses, each address 4 above the last. It does this while the execute stage works on earlier instructions. Returned words go into a small register queue. Each word is stored with the address it was fetched from, and the execute stage takes entries from the head through a valid/ready pop handshake.

A taken branch drives the redirect input with the target address. All queued words are discarded and fetching restarts at the target. Memory must return responses in request order. Responses that belong to requests issued before the redirect, including one accepted in the redirect cycle, are counted as stale and dropped when they arrive, so no word from the abandoned path ever reaches execute. A request is only issued when its response is certain to find a free queue slot, which bounds the queue at `DEPTH` entries.

Top module: `ifq_prefetch`

## Requirements
- R1: During and right after reset, `deq_valid` is 0, `req_valid` is 1 and `req_addr` equals the `RESET_PC` parameter.
- R2: Every request accepted (`req_valid` and `req_ready` high at a clock edge) without a redirect in that cycle is followed by a request address exactly 4 larger.
- R3: Queued entries plus outstanding requests never exceed `DEPTH` (default 4). With a full queue and nothing popped, `req_valid` stays low and exactly `DEPTH` requests have been issued since the queue was last empty.
- R4: Entries leave the queue in fetch order. Each one carries the instruction word returned for its address, and the address on `deq_pc` increases by 4 from one pop to the next until a redirect.
- R5: A pop and a response arriving in the same cycle both take effect without loss. With memory always ready and responding one cycle later, the queue sustains close to one pop per cycle.
- R6: In the cycle after `redir_valid` is high, `deq_valid` is 0 and `req_addr` equals the redirect target.
- R7: Responses to requests accepted up to and including the redirect cycle are discarded. The first entry delivered after a redirect carries the target address.
- R8: While `req_valid` is high and `req_ready` is low, and no redirect occurs, the request stays valid with an unchanged address in the next cycle.
- R9: While `deq_valid` is high and `deq_ready` is low, and no redirect occurs, the head entry (`deq_pc`, `deq_instr`) stays valid and unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | XLEN | Byte address of the requested instruction |
| resp_valid | input | 1 | In-order response word present |
| resp_data | input | XLEN | Returned instruction word |
| redir_valid | input | 1 | Taken-branch redirect |
| redir_addr | input | XLEN | Redirect target address |
| deq_valid | output | 1 | Queue head is valid |
| deq_ready | input | 1 | Execute stage pops the head |
| deq_pc | output | XLEN | Address of the head instruction |
| deq_instr | output | XLEN | Head instruction word |

## Verification
The assertions check on every cycle that the credit bound is kept and that the stale count never exceeds the outstanding count. They also check that sequential addresses advance by 4, that a redirect empties the queue and loads the target, that stale responses never add an entry, and that requests and the head entry hold steady under back-pressure. Only the bench's scenarios can show the data side. That covers pairing each delivered word with the correct address across arbitrary memory latency and random redirects, throughput under simultaneous push and pop, and the exact count of requests issued before a stall.

// File: rtl/ifq_prefetch.sv
module ifq_prefetch #(
  parameter int XLEN = 32,
  parameter int DEPTH = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [XLEN-1:0] req_addr,
  input  logic            resp_valid,
  input  logic [XLEN-1:0] resp_data,
  input  logic            redir_valid,
  input  logic [XLEN-1:0] redir_addr,
  output logic            deq_valid,
  input  logic            deq_ready,
  output logic [XLEN-1:0] deq_pc,
  output logic [XLEN-1:0] deq_instr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW:0] CAP = (CW+1)'(DEPTH);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] fetch_pc, fill_pc;
  logic [XLEN-1:0] q_word [DEPTH];
  logic [XLEN-1:0] q_pc   [DEPTH];
  logic [PW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]   count, inflight, stale;
  logic [CW-1:0]   inflight_n;
  logic [CW:0]     pending;

  wire issue = req_valid && req_ready;
  wire live  = resp_valid && (stale == '0);
  wire push  = live && !redir_valid;
  wire pop   = deq_valid && deq_ready && !redir_valid;

  assign pending    = {1'b0, count} + {1'b0, inflight};
  assign req_valid  = pending < CAP;
  assign req_addr   = fetch_pc;
  assign deq_valid  = count != '0;
  assign deq_pc     = q_pc[rd_ptr];
  assign deq_instr  = q_word[rd_ptr];
  assign inflight_n = inflight + CW'(issue) - CW'(resp_valid);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      fill_pc  <= RESET_PC;
      inflight <= '0;
      stale    <= '0;
    end else begin
      inflight <= inflight_n;
      if (redir_valid) begin
        fetch_pc <= redir_addr;
        fill_pc  <= redir_addr;
        stale    <= inflight_n;
      end else begin
        if (issue) fetch_pc <= fetch_pc + STEP;
        if (push)  fill_pc  <= fill_pc + STEP;
        if (resp_valid && stale != '0) stale <= stale - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (redir_valid) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_word[wr_ptr] <= resp_data;
      q_pc[wr_ptr]   <= fill_pc;
    end
  end

  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CAP); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CW'(DEPTH))); // R3
  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !redir_valid) |=> (req_addr == $past(req_addr) + STEP)); // R2
  AST_REDIR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (!deq_valid && req_addr == $past(redir_addr))); // R6
  AST_STALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stale <= inflight); // R7
  AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && stale != '0 && !redir_valid && !pop) |=> (count == $past(count))); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !redir_valid) |=> (req_valid && $stable(req_addr))); // R8
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready && !redir_valid) |=> (deq_valid && $stable(deq_pc) && $stable(deq_instr))); // R9
endmodule

// File: tb/tb_ifq_prefetch.sv
module tb_ifq_prefetch;
  localparam logic [31:0] RPC = 32'h0000_0100;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid, req_ready = 0, resp_valid = 0, redir_valid = 0, deq_valid, deq_ready = 0;
  logic [31:0] req_addr, resp_data = 0, redir_addr = 0, deq_pc, deq_instr;

  ifq_prefetch #(.XLEN(32), .DEPTH(DEPTH), .RESET_PC(RPC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_pc(deq_pc), .deq_instr(deq_instr));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mq [64];
  int mh = 0, mt = 0, n_issued = 0, n_pops = 0;
  logic [31:0] exp_pc = RPC;
  bit p_req_wait = 0, p_head_wait = 0, p_redir = 0;
  logic [31:0] p_req_addr, p_pc, p_instr, p_tgt;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int resp_pct, input int ready_pct, input int pop_pct,
                      input bit do_redir, input logic [31:0] tgt);
    @(negedge clk);
    if (p_redir) begin
      chk(!deq_valid, "R6 queue empty after redirect", 32'(deq_valid), 0);
      chk(req_addr == p_tgt, "R6 fetch at target", req_addr, p_tgt);
    end else begin
      if (p_req_wait) chk(req_valid && req_addr == p_req_addr, "R8 request held", req_addr, p_req_addr);
      if (p_head_wait) chk(deq_valid && deq_pc == p_pc && deq_instr == p_instr, "R9 head held", deq_pc, p_pc);
    end
    resp_valid = 0;
    if (mh != mt && ($urandom % 100) < resp_pct) begin
      resp_valid = 1;
      resp_data = word_of(mq[mh % 64]);
      mh++;
    end
    redir_valid = do_redir;
    redir_addr = tgt;
    req_ready = ($urandom % 100) < ready_pct;
    if (req_valid && req_ready) begin
      mq[mt % 64] = req_addr;
      mt++;
      n_issued++;
    end
    deq_ready = !do_redir && (($urandom % 100) < pop_pct);
    if (deq_valid && deq_ready) begin
      chk(deq_pc == exp_pc, "R4 R7 popped address", deq_pc, exp_pc);
      chk(deq_instr == word_of(exp_pc), "R4 popped word", deq_instr, word_of(exp_pc));
      exp_pc += 4;
      n_pops++;
    end
    if (do_redir) begin
      exp_pc = tgt;
      n_issued = 0;
    end
    p_redir = do_redir;
    p_req_wait = req_valid && !req_ready;
    p_req_addr = req_addr;
    p_head_wait = deq_valid && !deq_ready;
    p_pc = deq_pc;
    p_instr = deq_instr;
    p_tgt = tgt;
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(!deq_valid && req_valid && req_addr == RPC, "R1 state in reset", req_addr, RPC);
    rst_n = 1;
    @(negedge clk);
    chk(!deq_valid, "R1 queue empty", 32'(deq_valid), 0);
    chk(req_valid && req_addr == RPC, "R1 first fetch", req_addr, RPC);

    // R3: fill without popping
    n_issued = 0;
    repeat (20) step(100, 100, 0, 0, 0);
    @(negedge clk);
    chk(!req_valid, "R3 stall when full", 32'(req_valid), 0);
    chk(n_issued == DEPTH, "R3 issued count", n_issued, DEPTH);
    chk(deq_valid, "R3 data queued", 32'(deq_valid), 1);
    repeat (10) step(100, 100, 100, 0, 0);

    // R5: streaming with push and pop in the same cycles
    n_pops = 0;
    repeat (40) step(100, 100, 100, 0, 0);
    chk(n_pops >= 30, "R5 throughput", n_pops, 30);

    // R7: stale responses held back, then released after a redirect
    repeat (6) step(0, 100, 0, 0, 0);
    repeat (4) step(0, 100, 100, 0, 0);
    step(0, 100, 0, 1, 32'h0000_8000);
    n_issued = 0;
    repeat (14) step(100, 100, 0, 0, 0);
    chk(n_issued == DEPTH, "R7 new-path requests", n_issued, DEPTH);
    @(negedge clk);
    chk(deq_valid && deq_pc == 32'h0000_8000, "R7 first entry at target", deq_pc, 32'h0000_8000);
    repeat (10) step(100, 100, 100, 0, 0);

    // Random mix of back-pressure, latency and redirects
    for (int i = 0; i < 4000; i++) begin
      bit r = ($urandom % 100) < 3;
      step(20 + $urandom % 80, 20 + $urandom % 80, 20 + $urandom % 80, r,
           {14'd0, 16'($urandom), 2'b00});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule